// File: doc/BRIEF.md
# Write-Protected Seconds Clock Registers

This block keeps a 32-bit count of elapsed seconds and exposes it to a processor over a small 16-bit register bus. The count is read as two 16-bit halves. It advances by one on each one-second tick. The tick comes either from a single-cycle pulse input or from an internal divider of the system clock. A parameter selects the source.

Changing the time is guarded by a one-bit arming register. Software first sets the arm bit. It then writes the low half, then the high half. Writing the high half drops the arm bit on its own, so the guard closes after the sequence. While the block is not armed, time writes are discarded. Reads return data one clock after the read strobe. The bus carries no handshake: every access completes in one cycle, so there is no back-pressure.

Top module: `scr_top`

## Requirements
- R1: After reset the time value equals the EPOCH parameter and the arm bit is 0.
- R2: A read strobe at offset 0x00 returns time bits 31:16, and one at offset 0x04 returns bits 15:0. The data appears on rd_data in the cycle after the strobe. In any cycle after a cycle without a read strobe, rd_data is 0.
- R3: Offset 0x08 is the arm register. A write stores only wr_data bit 0, and a read of it always returns 0.
- R4: A write to offset 0x00 or 0x04 while the arm bit is 0 leaves the time value unchanged.
- R5: While armed, a write to offset 0x04 replaces time bits 15:0 only, and the arm bit stays 1.
- R6: While armed, a write to offset 0x00 replaces time bits 31:16 only and clears the arm bit in the same cycle.
- R7: Any offset other than 0x00, 0x04 and 0x08 reads as 0. Writes to it change neither the time nor the arm bit.
- R8: Each tick adds one to the 32-bit time value, wrapping from 0xFFFFFFFF to 0.
- R9: If an armed time write and a tick fall in the same cycle, the written half takes the written data. The other half takes the tick's effect: the carry out of the low half for a low write, and low plus one (carry dropped) for a high write.
- R10: With the internal divider selected (USE_EXT_TICK=0), the time advances exactly once every CLKS_PER_SEC clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | One-cycle seconds pulse, used when USE_EXT_TICK=1 |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 16 | Read data, valid the cycle after rd_en, zero otherwise |

## Verification
The checker assumes the following about the inputs:
- The external tick is a single-cycle pulse.
- The address is stable during any cycle in which a strobe is high.
- At most one write is issued per cycle.

The bench drives every strobe, address and tick from a falling edge and holds it for exactly one clock. Collision cases raise a tick and a write in the same cycle on purpose. A second instance, running its internal divider with a short period, is observed only through a continuously held read of the low half.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int DATA_W  = 16;
  localparam int TIME_W  = 2 * DATA_W;
  localparam int OFS_HI  = 'h00;
  localparam int OFS_LO  = 'h04;
  localparam int OFS_ARM = 'h08;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2,
    SEL_ARM  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/scr_decode.sv
module scr_decode
  import scr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(OFS_HI);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(OFS_LO);
  localparam logic [ADDR_W-1:0] A_ARM = ADDR_W'(OFS_ARM);

  always_comb begin
    if (addr == A_HI)       sel = SEL_HI;
    else if (addr == A_LO)  sel = SEL_LO;
    else if (addr == A_ARM) sel = SEL_ARM;
    else                    sel = SEL_NONE;
  end
endmodule

// File: rtl/scr_tick_gen.sv
module scr_tick_gen #(
  parameter bit USE_EXT_TICK = 1'b1,
  parameter int CLKS_PER_SEC = 200_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_out
);
  localparam int CNT_W = $clog2(CLKS_PER_SEC > 1 ? CLKS_PER_SEC : 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_SEC - 1);

  generate
    if (USE_EXT_TICK) begin : g_ext
      logic unused_ext;
      assign unused_ext = clk ^ rst_n;
      assign tick_out   = tick_in;
    end else begin : g_div
      logic [CNT_W-1:0] cnt_q;
      logic             unused_div;
      assign unused_div = tick_in;
      always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_out = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/scr_time_core.sv
module scr_time_core
  import scr_pkg::*;
#(
  parameter logic [31:0] EPOCH = 32'h3A00_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_hi,
  input  logic              load_lo,
  input  logic [DATA_W-1:0] load_data,
  output logic [TIME_W-1:0] time_q
);
  logic [DATA_W:0]   lo_sum;
  logic [DATA_W-1:0] nxt_lo;
  logic [DATA_W-1:0] nxt_hi;

  always_comb begin
    lo_sum = {1'b0, time_q[DATA_W-1:0]} + {{DATA_W{1'b0}}, tick};
    nxt_lo = load_lo ? load_data : lo_sum[DATA_W-1:0];
    nxt_hi = load_hi ? load_data
                     : time_q[TIME_W-1:DATA_W] + {{(DATA_W-1){1'b0}}, lo_sum[DATA_W]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) time_q <= EPOCH;
    else        time_q <= {nxt_hi, nxt_lo};
  end
endmodule

// File: rtl/scr_top.sv
module scr_top
  import scr_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter bit          USE_EXT_TICK = 1'b1,
  parameter int          CLKS_PER_SEC = 200_000_000,
  parameter logic [31:0] EPOCH        = 32'h3A00_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  reg_sel_e          sel;
  logic              tick_w;
  logic              arm_q;
  logic              load_hi;
  logic              load_lo;
  logic [TIME_W-1:0] time_w;
  logic [DATA_W-1:0] rd_mux;

  scr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  scr_tick_gen #(
    .USE_EXT_TICK (USE_EXT_TICK),
    .CLKS_PER_SEC (CLKS_PER_SEC)
  ) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (tick_in),
    .tick_out (tick_w)
  );

  assign load_hi = wr_en && (sel == SEL_HI) && arm_q;
  assign load_lo = wr_en && (sel == SEL_LO) && arm_q;

  scr_time_core #(.EPOCH(EPOCH)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_w),
    .load_hi   (load_hi),
    .load_lo   (load_lo),
    .load_data (wr_data),
    .time_q    (time_w)
  );

  // Arm latch: explicit write sets/clears, high-half write closes it.
  always_ff @(posedge clk) begin
    if (!rst_n)                            arm_q <= 1'b0;
    else if (wr_en && (sel == SEL_ARM))    arm_q <= wr_data[0];
    else if (wr_en && (sel == SEL_HI))     arm_q <= 1'b0;
  end

  always_comb begin
    unique case (sel)
      SEL_HI:  rd_mux = time_w[TIME_W-1:DATA_W];
      SEL_LO:  rd_mux = time_w[DATA_W-1:0];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
    else            rd_data <= '0;
  end
endmodule

// File: rtl/scr_checker.sv
module scr_checker
  import scr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              tick,
  input logic [TIME_W-1:0] time_q,
  input logic              arm_q
);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(OFS_HI);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(OFS_LO);
  localparam logic [ADDR_W-1:0] A_ARM = ADDR_W'(OFS_ARM);

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0);

  a_r3_arm_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && bus_addr == A_ARM |=> arm_q == $past(wr_data[0]));

  a_r3_arm_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && bus_addr == A_ARM |=> rd_data == '0);

  a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_q && !tick |=> time_q == $past(time_q));

  a_r5_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && bus_addr == A_LO && arm_q |=> time_q[DATA_W-1:0] == $past(wr_data) && arm_q);

  a_r6_hi_close: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && bus_addr == A_HI |=> !arm_q);

  a_r7_other_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && bus_addr != A_HI && bus_addr != A_LO |=> rd_data == '0);

  a_r8_tick_inc: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_en |=> time_q == $past(time_q) + 32'd1);

  a_r9_hi_collide: assert property (@(posedge clk) disable iff (!rst_n)
    tick && wr_en && bus_addr == A_HI && arm_q
    |=> time_q[TIME_W-1:DATA_W] == $past(wr_data));
endmodule

bind scr_top scr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .tick     (tick_w),
  .time_q   (time_w),
  .arm_q    (arm_q)
);

// File: tb/scr_top_tb_top.sv
`timescale 1ns/1ps
module scr_top_tb_top;
  localparam logic [31:0] EPOCH = 32'h3A00_0000;
  localparam int DIV_N = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic [15:0] div_rd_data;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  scr_top #(.EPOCH(EPOCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_addr(bus_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  scr_top #(.EPOCH(EPOCH), .USE_EXT_TICK(1'b0), .CLKS_PER_SEC(DIV_N)) dut_div_i (
    .clk(clk), .rst_n(rst_n), .tick_in(1'b0), .bus_addr(8'h04),
    .wr_en(1'b0), .wr_data(16'h0), .rd_en(1'b1), .rd_data(div_rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One-cycle operation launched from a falling edge.
  task automatic op(input logic w, input logic r, input logic [7:0] a,
                    input logic [15:0] d, input logic t);
    @(negedge clk);
    wr_en = w; rd_en = r; bus_addr = a; wr_data = d; tick_in = t;
    @(negedge clk);
    wr_en = 0; rd_en = 0; tick_in = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    op(0, 1, a, 16'h0, 0);
    v = rd_data;
  endtask

  task automatic rd_time(output logic [31:0] v);
    logic [15:0] h, l;
    rd(8'h00, h);
    rd(8'h04, l);
    v = {h, l};
  endtask

  task automatic set_time(input logic [31:0] t);
    op(1, 0, 8'h08, 16'h0001, 0);
    op(1, 0, 8'h04, t[15:0], 0);
    op(1, 0, 8'h00, t[31:16], 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    logic [15:0] a;
    rd_time(v);
    check("R1 epoch", v, EPOCH);
    rd(8'h08, a);
    check("R3 arm reads zero", {16'h0, a}, 0);
    @(negedge clk);
    check("R2 idle rd_data", {16'h0, rd_data}, 0);
    op(1, 0, 8'h04, 16'hBEEF, 0);
    rd_time(v);
    check("R1 arm clear after reset", v, EPOCH);
  endtask

  task automatic t_locked();
    logic [31:0] v;
    op(1, 0, 8'h00, 16'h1234, 0);
    op(1, 0, 8'h04, 16'h5678, 0);
    rd_time(v);
    check("R4 locked writes ignored", v, EPOCH);
  endtask

  task automatic t_sequence();
    logic [31:0] v;
    logic [15:0] a;
    op(1, 0, 8'h08, 16'h0001, 0);
    rd(8'h08, a);
    check("R3 arm read zero while armed", {16'h0, a}, 0);
    op(1, 0, 8'h04, 16'h1234, 0);
    rd_time(v);
    check("R5 low replaced", v, {EPOCH[31:16], 16'h1234});
    op(1, 0, 8'h04, 16'h5678, 0);
    rd_time(v);
    check("R5 still armed", v, {EPOCH[31:16], 16'h5678});
    op(1, 0, 8'h00, 16'hABCD, 0);
    rd_time(v);
    check("R6 high replaced", v, 32'hABCD_5678);
    op(1, 0, 8'h00, 16'h1111, 0);
    op(1, 0, 8'h04, 16'h2222, 0);
    rd_time(v);
    check("R6 arm closed", v, 32'hABCD_5678);
  endtask

  task automatic t_arm_bit0();
    logic [31:0] v;
    op(1, 0, 8'h08, 16'h0001, 0);
    op(1, 0, 8'h08, 16'hFFFE, 0);
    op(1, 0, 8'h04, 16'h9999, 0);
    rd_time(v);
    check("R3 only bit0 stored", v, 32'hABCD_5678);
  endtask

  task automatic t_other();
    logic [31:0] v;
    logic [15:0] a;
    op(1, 0, 8'h08, 16'h0001, 0);
    op(1, 0, 8'h0C, 16'h0000, 0);
    op(1, 0, 8'h02, 16'h7777, 0);
    rd(8'h0C, a);
    check("R7 other reads zero", {16'h0, a}, 0);
    rd(8'h02, a);
    check("R7 other reads zero 0x02", {16'h0, a}, 0);
    rd_time(v);
    check("R7 time untouched", v, 32'hABCD_5678);
    op(1, 0, 8'h04, 16'h4444, 0);
    rd_time(v);
    check("R7 arm untouched", v, 32'hABCD_4444);
    op(1, 0, 8'h00, 16'hABCD, 0);
  endtask

  task automatic t_tick();
    logic [31:0] v;
    set_time(32'h0001_FFFF);
    op(0, 0, 8'h00, 16'h0, 1);
    rd_time(v);
    check("R8 carry into high", v, 32'h0002_0000);
    op(0, 0, 8'h00, 16'h0, 1);
    op(0, 0, 8'h00, 16'h0, 1);
    rd_time(v);
    check("R8 two ticks", v, 32'h0002_0002);
    set_time(32'hFFFF_FFFF);
    op(0, 0, 8'h00, 16'h0, 1);
    rd_time(v);
    check("R8 wrap", v, 32'h0000_0000);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    set_time(32'h0005_FFFF);
    op(1, 0, 8'h08, 16'h0001, 0);
    op(1, 0, 8'h04, 16'h0010, 1);
    rd_time(v);
    check("R9 low write + tick", v, 32'h0006_0010);
    op(1, 0, 8'h00, 16'h0100, 1);
    rd_time(v);
    check("R9 high write + tick", v, 32'h0100_0011);
    set_time(32'h0200_FFFF);
    op(1, 0, 8'h08, 16'h0001, 0);
    op(1, 0, 8'h00, 16'h0300, 1);
    rd_time(v);
    check("R9 high write drops carry", v, 32'h0300_0000);
    op(1, 0, 8'h04, 16'h5555, 1);
    rd_time(v);
    check("R4 locked write + tick", v, 32'h0300_0001);
  endtask

  task automatic t_div();
    logic [15:0] d0, d1;
    @(negedge clk);
    d0 = div_rd_data;
    repeat (DIV_N * 6) @(negedge clk);
    d1 = div_rd_data;
    check("R10 divider six periods", {16'h0, d1 - d0}, 6);
    repeat (DIV_N) @(negedge clk);
    d0 = div_rd_data;
    check("R10 divider one period", {16'h0, d0 - d1}, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_locked();
    t_sequence();
    t_arm_bit0();
    t_other();
    t_tick();
    t_collide();
    t_div();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule